// File: doc/BRIEF.md
# Quad I/O Read Slave with Execute-in-Place

This block is the read path of a serial flash device as seen from the bus. A host selects the device, clocks in the quad I/O read opcode 0xEB on data line 0, then sends a 24-bit address and a mode byte followed by dummy clocks over all four data lines. The block then streams bytes from an attached memory, four bits per serial clock, starting at the captured address and counting upward.

The mode byte controls the next transaction. When its continuation bit is clear, the block stays in execute-in-place operation: the next chip-select cycle begins directly with the quad address and skips the opcode. This cuts eight serial clocks from every random read that follows. While a write is in progress elsewhere in the device, the data phase outputs zeros in place of memory contents.

All serial inputs are sampled on a fast system clock and are assumed to be synchronous to it. Serial clock edges are found by comparing each sample with the one before. The serial bus idles with its clock low.

Top module: `qspi_xip_reader`

## Requirements
- R1: After reset, dq_oe is 0, dq_out is 0000, and the device expects an opcode, so execute-in-place is off.
- R2: In opcode mode, the first 8 rising sck edges after cs_n falls shift in the opcode from dq_in[0], MSB first. The value 0xEB starts a quad read.
- R3: Any other opcode is ignored until cs_n rises. dq_oe stays 0 for that whole transaction, and the next transaction again expects an opcode.
- R4: The address takes 6 rising edges, 4 bits each, with dq_in[3] as the most significant bit of each nibble and the high nibble first. mem_addr is the low MEM_AW bits of the 24-bit address.
- R5: A further 8 rising edges follow the address. The first two carry the mode byte, high nibble first. dq_oe is 0 during the opcode, address and dummy phases, and rises only on the rising edge that ends the last dummy clock.
- R6: In the data phase, each falling sck edge drives one nibble on dq_out, high nibble first. Bytes come from consecutive addresses, and the address wraps modulo 2^MEM_AW.
- R7: While wip is high, each nibble driven is 0000. The byte address advances only after a low nibble has been driven with wip low.
- R8: At the rising edge of cs_n, a captured mode byte with bit 4 equal to 0 puts the device in execute-in-place, and the next transaction starts at the address phase. If bit 4 is 1, the next transaction expects an opcode.
- R9: A transaction that ends before both mode nibbles arrive leaves execute-in-place off.
- R10: Asserting rst_n low ends execute-in-place.
- R11: One system clock after cs_n goes high, dq_oe is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, idles low |
| dq_in | input | 4 | Input value of the data lines |
| dq_out | output | 4 | Output value of the data lines |
| dq_oe | output | 1 | Drive enable for the data lines |
| wip | input | 1 | Write in progress, which forces zero data |
| mem_addr | output | MEM_AW | Read address to the memory |
| mem_rdata | input | 8 | Memory byte at mem_addr, combinational |

## Verification
A rising sck is sampled at the next system clock edge, and state such as the opcode, address nibble or phase change takes effect right after that edge. A falling sck updates dq_out one system clock later. The bench holds each sck level for two system clocks and reads dq_out and dq_oe at the end of the low half. That read falls one full clock after the nibble was updated and just before the next rising edge that would move the state on. The dq_oe check after deselect is taken one clock after cs_n rises, which is where R11 places it.

// File: rtl/qspi_xip_reader.sv
module qspi_xip_reader #(
  parameter int MEM_AW     = 16,
  parameter int ADDR_CLKS  = 6,
  parameter int DUMMY_CLKS = 8,
  parameter logic [7:0] OPCODE = 8'hEB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic              dq_oe,
  input  logic              wip,
  output logic [MEM_AW-1:0] mem_addr,
  input  logic [7:0]        mem_rdata
);
  localparam int ABITS = 4 * ADDR_CLKS;
  localparam int CW    = $clog2(ADDR_CLKS + DUMMY_CLKS + 8) + 1;

  typedef enum logic [2:0] {S_CMD, S_ADDR, S_DUMMY, S_DATA, S_IGN} st_t;

  st_t             st;
  logic            sck_q, cs_q, xip, mode_ok, nib_lo;
  logic [CW-1:0]   cnt;
  logic [7:0]      sh, mode;
  logic [ABITS-1:0] addr;

  wire rise    = sck & ~sck_q & ~cs_n;
  wire fall    = ~sck & sck_q & ~cs_n;
  wire cs_up   = cs_n & ~cs_q;
  wire xip_nxt = cs_up ? (mode_ok & ~mode[4]) : xip;
  wire [7:0] sh_nxt = {sh[6:0], dq_in[0]};

  assign dq_oe    = (st == S_DATA);
  assign mem_addr = addr[MEM_AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_CMD;
      sck_q   <= 1'b0;
      cs_q    <= 1'b1;
      xip     <= 1'b0;
      mode_ok <= 1'b0;
      nib_lo  <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      mode    <= '0;
      addr    <= '0;
      dq_out  <= '0;
    end else begin
      sck_q <= sck;
      cs_q  <= cs_n;
      if (cs_n) begin
        xip     <= xip_nxt;
        st      <= xip_nxt ? S_ADDR : S_CMD;
        cnt     <= '0;
        nib_lo  <= 1'b0;
        mode_ok <= 1'b0;
      end else begin
        if (rise) begin
          case (st)
            S_CMD: begin
              sh <= sh_nxt;
              if (cnt == CW'(7)) begin
                cnt <= '0;
                st  <= (sh_nxt == OPCODE) ? S_ADDR : S_IGN;
              end else cnt <= cnt + 1'b1;
            end
            S_ADDR: begin
              addr <= {addr[ABITS-5:0], dq_in};
              if (cnt == CW'(ADDR_CLKS - 1)) begin
                cnt <= '0;
                st  <= S_DUMMY;
              end else cnt <= cnt + 1'b1;
            end
            S_DUMMY: begin
              if (cnt < CW'(2)) mode <= {mode[3:0], dq_in};
              if (cnt == CW'(1)) mode_ok <= 1'b1;
              if (cnt == CW'(DUMMY_CLKS - 1)) begin
                cnt    <= '0;
                nib_lo <= 1'b0;
                st     <= S_DATA;
              end else cnt <= cnt + 1'b1;
            end
            default: ;
          endcase
        end
        if (fall && st == S_DATA) begin
          if (wip)         dq_out <= 4'h0;
          else if (nib_lo) dq_out <= mem_rdata[3:0];
          else             dq_out <= mem_rdata[7:4];
          if (nib_lo && !wip) addr <= addr + 1'b1;
          nib_lo <= ~nib_lo;
        end
      end
    end
  end
endmodule

module qspi_xip_reader_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       sck,
  input logic       wip,
  input logic [3:0] dq_out,
  input logic       dq_oe
);
  logic sck_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sck_d <= 1'b0;
    else        sck_d <= sck;

  wire fall_ev = sck_d & ~sck & ~cs_n;
  wire rise_ev = ~sck_d & sck & ~cs_n;

  p_oe_off_after_deselect_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !dq_oe);
  p_out_moves_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dq_out) |-> $past(fall_ev));
  p_wip_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_ev && dq_oe && wip) |=> (dq_out == 4'h0));
  p_oe_starts_on_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(rise_ev));
endmodule

bind qspi_xip_reader qspi_xip_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck),
  .wip(wip), .dq_out(dq_out), .dq_oe(dq_oe)
);

// File: tb/test_qspi_xip_reader.sv
module test_qspi_xip_reader;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sck = 1'b0;
  logic [3:0]    dq_in = 4'h0;
  logic [3:0]    dq_out;
  logic          dq_oe;
  logic          wip = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_rdata;

  int vecs = 0;
  int errs = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(input logic [AW-1:0] a);
    return (a[7:0] * 8'd29) ^ a[15:8] ^ 8'h5A;
  endfunction

  assign mem_rdata = mem_f(mem_addr);

  qspi_xip_reader #(.MEM_AW(AW)) i_qspi_xip_reader (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .wip(wip),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic spi_clk(input logic [3:0] d, output logic [3:0] q, output logic oe);
    dq_in = d;
    sck = 1'b0;
    repeat (2) @(negedge clk);
    q  = dq_out;
    oe = dq_oe;
    sck = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic sel();
    @(negedge clk);
    cs_n = 1'b0;
    sck  = 1'b0;
    @(negedge clk);
  endtask

  task automatic desel();
    cs_n = 1'b1;
    @(negedge clk);
    chk("R11 oe after deselect", dq_oe, 0);
    sck = 1'b0;
    wip = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic xfer(input bit with_cmd, input logic [23:0] a, input logic [7:0] mode,
                      input int nbytes, input int wip_nibs, input string req);
    logic [3:0] q;
    logic oe;
    logic [7:0] b;
    int k;
    sel();
    if (with_cmd)
      for (int i = 7; i >= 0; i--) begin
        spi_clk({3'b0, OPCODE_BIT(i)}, q, oe);
        chk({req, " R5 oe low in opcode"}, oe, 0);
      end
    for (int i = 5; i >= 0; i--) begin
      spi_clk(a[i*4 +: 4], q, oe);
      chk({req, " R5 oe low in address"}, oe, 0);
    end
    for (int i = 0; i < 8; i++) begin
      spi_clk(i == 0 ? mode[7:4] : (i == 1 ? mode[3:0] : 4'hA), q, oe);
      chk({req, " R5 oe low in dummy"}, oe, 0);
    end
    for (int i = 0; i < nbytes * 2; i++) begin
      wip = (i < wip_nibs);
      spi_clk(4'h0, q, oe);
      chk({req, " R6 oe high in data"}, oe, 1);
      if (i < wip_nibs) chk({req, " R7 wip nibble"}, q, 0);
      else begin
        k = i - wip_nibs;
        b = mem_f(AW'(a + 24'(k / 2)));
        chk({req, " R6 data nibble"}, q, (k % 2 == 0) ? b[7:4] : b[3:0]);
      end
    end
    desel();
  endtask

  function automatic logic OPCODE_BIT(input int i);
    logic [7:0] op = 8'hEB;
    return op[i];
  endfunction

  task automatic t_reset();
    chk("R1 oe at reset", dq_oe, 0);
    chk("R1 dq_out at reset", dq_out, 0);
    xfer(1, 24'h000123, 8'hFF, 2, 0, "R1 R2 first read needs opcode");
  endtask

  task automatic t_basic();
    xfer(1, 24'h004A10, 8'hFF, 4, 0, "R2 R4 basic");
    xfer(1, 24'h0000FF, 8'h10, 3, 0, "R6 byte step");
  endtask

  task automatic t_wrap();
    xfer(1, 24'hABFFFE, 8'hFF, 4, 0, "R4 R6 truncate and wrap");
  endtask

  task automatic t_badcmd();
    logic [3:0] q;
    logic oe;
    logic [7:0] op = 8'h0B;
    sel();
    for (int i = 7; i >= 0; i--) spi_clk({3'b0, op[i]}, q, oe);
    for (int i = 0; i < 20; i++) begin
      spi_clk(4'h5, q, oe);
      chk("R3 oe low after bad opcode", oe, 0);
    end
    desel();
    xfer(1, 24'h000777, 8'hFF, 2, 0, "R3 opcode mode after bad opcode");
  endtask

  task automatic t_wip();
    xfer(1, 24'h001200, 8'hFF, 3, 4, "R7 wip holds address");
  endtask

  task automatic t_xip();
    xfer(1, 24'h002000, 8'h00, 2, 0, "R8 enter xip");
    xfer(0, 24'h003456, 8'hEF, 2, 0, "R8 xip no opcode");
    xfer(0, 24'h00ABCD, 8'hFF, 2, 0, "R8 xip exit request");
    xfer(1, 24'h000042, 8'hFF, 2, 0, "R8 opcode after exit");
  endtask

  task automatic t_xip_abort();
    logic [3:0] q;
    logic oe;
    xfer(1, 24'h000010, 8'h00, 1, 0, "R9 enter xip");
    sel();
    for (int i = 0; i < 3; i++) begin
      spi_clk(4'h1, q, oe);
      chk("R9 oe low in short xip", oe, 0);
    end
    desel();
    xfer(1, 24'h000500, 8'hFF, 2, 0, "R9 opcode after short xip");
  endtask

  task automatic t_xip_reset();
    xfer(1, 24'h000020, 8'h00, 1, 0, "R10 enter xip");
    do_reset();
    chk("R10 oe after reset", dq_oe, 0);
    xfer(1, 24'h000600, 8'hFF, 2, 0, "R10 opcode after reset");
  endtask

  initial begin
    do_reset();
    t_reset();
    t_basic();
    t_wrap();
    t_badcmd();
    t_wip();
    t_xip();
    t_xip_abort();
    t_xip_reset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      vecs++;
      errs++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule